// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block lets a host reach the configuration registers of devices behind it through two small register windows. The first window is an address window: software writes one 32-bit word that names a target bus, a device and function, a register offset and an enable flag. The second window is a data window. A read or write of 1, 2 or 4 bytes there turns into a single downstream configuration request aimed at the latched target. The byte offset within the data window is merged into the register offset.

Before a request goes out, the bridge filters it. It checks status flags that the downstream side returns for the decoded target: whether a device is there, whether it is powered, whether it has been ejected, whether it was hotplugged, and whether function 0 of the same device exists. It also checks the register offset against a configurable limit of the configuration space. A filtered read answers all ones. A filtered write is dropped and never reaches the downstream side. A write that runs past the limit is trimmed to the bytes that remain below it.

Read answers come back on a registered response port two cycles after the request.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address latch holds zero. `host_rvalid` and `dn_req` are low, an address-window read returns 0, and a data-window read returns 32'hFFFFFFFF with no downstream request.
- R2: The address latch is written only by an address-window access (`host_sel`=0) with `host_we`=1, `host_len`=4 and `host_off`=0. An address-window write of any other length or offset leaves the latch unchanged.
- R3: An address-window read returns the full 32-bit latch for every `host_off` and every `host_len`.
- R4: Latch bit 31 is the enable. While it is 0, data-window reads return 32'hFFFFFFFF and data-window writes raise no `dn_req`.
- R5: `dn_bus` is latch bits 23:16 and `dn_devfn` is latch bits 15:8, with the function number in `dn_devfn[2:0]` and the device in `dn_devfn[7:3]`. `dn_reg` is latch bits 7:0 bitwise ORed with `host_off`.
- R6: When `dn_present` is 0, a data read returns all ones and a data write raises no `dn_req`.
- R7: When `dn_powered` is 0 or `dn_ejected` is 1, a data read returns all ones and a data write raises no `dn_req`.
- R8: A target with `dn_hotplug`=1, a nonzero function number and `dn_fn0_present`=0 is hidden: reads return all ones and writes raise no `dn_req`. When function 0 is present, the same target is served normally.
- R9: If `dn_reg` is at or above `CFG_LIMIT`, the access is filtered: reads return all ones and writes are dropped. Otherwise `dn_len` (a byte count from 1 to 4) equals the smaller of `host_len` and `CFG_LIMIT - dn_reg`.
- R10: A host read accepted in cycle T gives a one-cycle `host_rvalid` in cycle T+2. A write never produces `host_rvalid`. For a forwarded read, `host_rdata` is `dn_rdata` (sampled in T+1) with every byte lane at or above `dn_len` cleared to zero.
- R11: `dn_req` is high only in a cycle where `host_req` targets the data window and the access passes every filter. It then carries `dn_we`=`host_we` and `dn_wdata`=`host_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = address window, 1 = data window |
| host_off | input | 2 | Byte offset within the window |
| host_len | input | 3 | Access size in bytes (1, 2 or 4) |
| host_wdata | input | 32 | Write data, right-aligned |
| host_rvalid | output | 1 | Read response valid |
| host_rdata | output | 32 | Read response data, right-aligned |
| dn_req | output | 1 | Downstream request strobe |
| dn_we | output | 1 | Downstream write flag |
| dn_bus | output | 8 | Target bus number |
| dn_devfn | output | 8 | Target device (7:3) and function (2:0) |
| dn_reg | output | 8 | Target register offset |
| dn_len | output | 3 | Forwarded byte count (1 to 4) |
| dn_wdata | output | 32 | Downstream write data |
| dn_present | input | 1 | A device exists at the decoded target |
| dn_powered | input | 1 | Target is powered |
| dn_ejected | input | 1 | Target has been ejected or partially unplugged |
| dn_hotplug | input | 1 | Target was hotplugged |
| dn_fn0_present | input | 1 | Function 0 of the target's device exists |
| dn_rdata | input | 32 | Downstream read data, valid the cycle after `dn_req` |

## Verification
A corrupted address latch shows up in the same cycle as the next data-window access. The target fields on `dn_bus`, `dn_devfn` and `dn_reg` come out wrong, and an address-window read returns the bad word two cycles later. Faults in the filter or the length clamp show as a `dn_req` that should not fire, or one that is missing, in the request cycle itself. They also show as a wrong `dn_len`, or as all-ones data where masked device data was expected. A broken stage of the response pipeline moves or drops `host_rvalid` away from exactly two cycles after the read, or leaves stale byte lanes in `host_rdata`. The sweep covers every status combination of the modelled devices and every offset near the limit, so each of these faults is seen within a few accesses of the first case that touches it.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned BYTE_LANES = WORD_W / BYTE_W;
  localparam int unsigned LEN_W      = 3;
  localparam int unsigned OFF_W      = 2;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned FN_W       = 3;
  localparam int unsigned EN_BIT     = 31;
  localparam int unsigned BUS_LSB    = 16;
  localparam int unsigned DEVFN_LSB  = 8;
  localparam int unsigned REG_LSB    = 0;

  typedef enum logic [1:0] {
    RSP_LATCH = 2'd0,
    RSP_FWD   = 2'd1,
    RSP_ONES  = 2'd2
  } rsp_kind_e;

  typedef struct packed {
    logic present;
    logic powered;
    logic ejected;
    logic hotplug;
    logic fn0_present;
  } dev_sts_t;
endpackage

// File: rtl/cfgb_addr_latch.sv
module cfgb_addr_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latch_q
);
  logic [W-1:0] latch_d;

  always_comb begin
    latch_d = latch_q;
    if (wr_en) latch_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end
endmodule

// File: rtl/cfgb_filter.sv
module cfgb_filter
  import cfgb_pkg::*;
#(
  parameter int unsigned CFG_LIMIT = 256
) (
  input  logic [WORD_W-1:0]  latch_q,
  input  logic [OFF_W-1:0]   port_off,
  input  logic [LEN_W-1:0]   req_len,
  input  dev_sts_t           sts,
  output logic [FIELD_W-1:0] bus,
  output logic [FIELD_W-1:0] devfn,
  output logic [FIELD_W-1:0] reg_off,
  output logic [LEN_W-1:0]   fwd_len,
  output logic               allow
);
  localparam int unsigned ROOM_W = FIELD_W + 1;
  localparam logic [ROOM_W-1:0] LIMIT_V = ROOM_W'(CFG_LIMIT);

  logic [ROOM_W-1:0] room;
  logic              in_range;
  logic              hidden;
  logic              unused_hi;

  assign unused_hi = ^latch_q[EN_BIT-1:BUS_LSB+FIELD_W];

  always_comb begin
    bus      = latch_q[BUS_LSB +: FIELD_W];
    devfn    = latch_q[DEVFN_LSB +: FIELD_W];
    reg_off  = latch_q[REG_LSB +: FIELD_W] | FIELD_W'(port_off);
    in_range = {1'b0, reg_off} < LIMIT_V;
    room     = LIMIT_V - {1'b0, reg_off};
    fwd_len  = (room < ROOM_W'(req_len)) ? room[LEN_W-1:0] : req_len;
    hidden   = sts.hotplug && (devfn[FN_W-1:0] != '0) && !sts.fn0_present;
    allow    = latch_q[EN_BIT] && in_range && sts.present && sts.powered
               && !sts.ejected && !hidden;
  end
endmodule

// File: rtl/cfgb_resp.sv
module cfgb_resp
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  rsp_kind_e         rd_kind,
  input  logic [WORD_W-1:0] latch_val,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic [WORD_W-1:0] dn_rdata,
  output logic              host_rvalid,
  output logic [WORD_W-1:0] host_rdata
);
  logic              s1_valid_q;
  rsp_kind_e         s1_kind_q;
  logic [LEN_W-1:0]  s1_len_q;
  logic [WORD_W-1:0] s1_latch_q;
  logic [WORD_W-1:0] lane_mask;
  logic [WORD_W-1:0] rdata_d;

  for (genvar b = 0; b < BYTE_LANES; b++) begin : g_lane
    assign lane_mask[b*BYTE_W +: BYTE_W] = {BYTE_W{s1_len_q > LEN_W'(b)}};
  end

  always_comb begin
    rdata_d = host_rdata;
    if (s1_valid_q) begin
      unique case (s1_kind_q)
        RSP_LATCH: rdata_d = s1_latch_q;
        RSP_FWD:   rdata_d = dn_rdata & lane_mask;
        default:   rdata_d = '1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_kind_q  <= RSP_ONES;
      s1_len_q   <= '0;
      s1_latch_q <= '0;
    end else begin
      s1_valid_q <= rd_fire;
      if (rd_fire) begin
        s1_kind_q  <= rd_kind;
        s1_len_q   <= rd_len;
        s1_latch_q <= latch_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= s1_valid_q;
      host_rdata  <= rdata_d;
    end
  end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
#(
  parameter int unsigned CFG_LIMIT = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic               host_sel,
  input  logic [OFF_W-1:0]   host_off,
  input  logic [LEN_W-1:0]   host_len,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic               host_rvalid,
  output logic [WORD_W-1:0]  host_rdata,
  output logic               dn_req,
  output logic               dn_we,
  output logic [FIELD_W-1:0] dn_bus,
  output logic [FIELD_W-1:0] dn_devfn,
  output logic [FIELD_W-1:0] dn_reg,
  output logic [LEN_W-1:0]   dn_len,
  output logic [WORD_W-1:0]  dn_wdata,
  input  logic               dn_present,
  input  logic               dn_powered,
  input  logic               dn_ejected,
  input  logic               dn_hotplug,
  input  logic               dn_fn0_present,
  input  logic [WORD_W-1:0]  dn_rdata
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(BYTE_LANES);

  logic [WORD_W-1:0] latch_q;
  logic              latch_wr;
  logic              allow;
  logic              rd_fire;
  rsp_kind_e         rd_kind;
  dev_sts_t          sts;

  always_comb begin
    sts.present     = dn_present;
    sts.powered     = dn_powered;
    sts.ejected     = dn_ejected;
    sts.hotplug     = dn_hotplug;
    sts.fn0_present = dn_fn0_present;
  end

  assign latch_wr = host_req && host_we && !host_sel
                    && (host_len == FULL_LEN) && (host_off == '0);

  cfgb_addr_latch #(.W(WORD_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (latch_wr),
    .wr_data (host_wdata),
    .latch_q (latch_q)
  );

  cfgb_filter #(.CFG_LIMIT(CFG_LIMIT)) u_filter (
    .latch_q  (latch_q),
    .port_off (host_off),
    .req_len  (host_len),
    .sts      (sts),
    .bus      (dn_bus),
    .devfn    (dn_devfn),
    .reg_off  (dn_reg),
    .fwd_len  (dn_len),
    .allow    (allow)
  );

  assign dn_req   = host_req && host_sel && allow;
  assign dn_we    = host_we;
  assign dn_wdata = host_wdata;

  assign rd_fire = host_req && !host_we;

  always_comb begin
    if (!host_sel)  rd_kind = RSP_LATCH;
    else if (allow) rd_kind = RSP_FWD;
    else            rd_kind = RSP_ONES;
  end

  cfgb_resp u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire     (rd_fire),
    .rd_kind     (rd_kind),
    .latch_val   (latch_q),
    .rd_len      (dn_len),
    .dn_rdata    (dn_rdata),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata)
  );
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker #(
  parameter int unsigned CFG_LIMIT = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_req,
  input logic       host_we,
  input logic       host_sel,
  input logic       host_rvalid,
  input logic       dn_req,
  input logic [7:0] dn_devfn,
  input logic [7:0] dn_reg,
  input logic [2:0] dn_len,
  input logic       dn_present,
  input logic       dn_powered,
  input logic       dn_ejected,
  input logic       dn_hotplug,
  input logic       dn_fn0_present,
  input logic       latch_en
);
  AST_REQ_FROM_DATA_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> (host_req && host_sel)); // R11

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> latch_en); // R4

  AST_REQ_TARGET_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> dn_present); // R6

  AST_REQ_TARGET_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> (dn_powered && !dn_ejected)); // R7

  AST_REQ_NOT_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> !(dn_hotplug && (dn_devfn[2:0] != 3'd0) && !dn_fn0_present)); // R8

  AST_LEN_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> ((dn_len != 3'd0) && (({1'b0, dn_reg} + {6'd0, dn_len}) <= 9'(CFG_LIMIT)))); // R9

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> ##1 host_rvalid); // R10

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we) |=> ##1 !host_rvalid); // R10
endmodule

bind cfg_port_bridge cfgb_checker #(.CFG_LIMIT(CFG_LIMIT)) u_cfgb_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_req       (host_req),
  .host_we        (host_we),
  .host_sel       (host_sel),
  .host_rvalid    (host_rvalid),
  .dn_req         (dn_req),
  .dn_devfn       (dn_devfn),
  .dn_reg         (dn_reg),
  .dn_len         (dn_len),
  .dn_present     (dn_present),
  .dn_powered     (dn_powered),
  .dn_ejected     (dn_ejected),
  .dn_hotplug     (dn_hotplug),
  .dn_fn0_present (dn_fn0_present),
  .latch_en       (latch_q[31])
);

// File: tb/test_cfg_port_bridge.sv
`timescale 1ns/1ps
module test_cfg_port_bridge;
  localparam int LIM = 240;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we, host_sel;
  logic [1:0]  host_off;
  logic [2:0]  host_len;
  logic [31:0] host_wdata;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic        dn_req, dn_we;
  logic [7:0]  dn_bus, dn_devfn, dn_reg;
  logic [2:0]  dn_len;
  logic [31:0] dn_wdata;
  logic        dn_present, dn_powered, dn_ejected, dn_hotplug, dn_fn0_present;
  logic [31:0] dn_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic        o_req, o_we, o_rvalid;
  logic [7:0]  o_bus, o_devfn, o_reg;
  logic [2:0]  o_len;
  logic [31:0] o_wdata, o_rdata;

  always #4 clk = ~clk;

  cfg_port_bridge #(.CFG_LIMIT(LIM)) i_cfg_port_bridge (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
    .host_off(host_off), .host_len(host_len), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_bus(dn_bus), .dn_devfn(dn_devfn),
    .dn_reg(dn_reg), .dn_len(dn_len), .dn_wdata(dn_wdata),
    .dn_present(dn_present), .dn_powered(dn_powered), .dn_ejected(dn_ejected),
    .dn_hotplug(dn_hotplug), .dn_fn0_present(dn_fn0_present), .dn_rdata(dn_rdata)
  );

  // Device model: buses 0 and 1, devices 0..5.
  // Device 5 has no function 0; device 3 is unpowered; device 4 function 1 is ejected.
  // Devices 4 and up are hotplugged.
  function automatic bit m_present(input int bus, input int dev, input int fn);
    return (bus <= 1) && (dev < 6) && ((fn == 0) ? (dev != 5) : (fn <= 2));
  endfunction
  function automatic bit m_powered(input int dev);
    return dev != 3;
  endfunction
  function automatic bit m_ejected(input int dev, input int fn);
    return (dev == 4) && (fn == 1);
  endfunction
  function automatic bit m_hotplug(input int dev);
    return dev >= 4;
  endfunction
  function automatic logic [31:0] pat(input logic [7:0] b, input logic [7:0] d, input logic [7:0] r);
    return {b ^ 8'hA5, d, r + 8'h11, r ^ 8'h3C};
  endfunction
  function automatic logic [31:0] lane_mask(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 4; i++) if (i < n) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  always_comb begin
    dn_present     = m_present(int'(dn_bus), int'(dn_devfn[7:3]), int'(dn_devfn[2:0]));
    dn_powered     = m_powered(int'(dn_devfn[7:3]));
    dn_ejected     = m_ejected(int'(dn_devfn[7:3]), int'(dn_devfn[2:0]));
    dn_hotplug     = m_hotplug(int'(dn_devfn[7:3]));
    dn_fn0_present = m_present(int'(dn_bus), int'(dn_devfn[7:3]), 0);
  end

  // The responder returns full-width data; the bridge must clear the unused lanes.
  always_ff @(posedge clk) begin
    if (dn_req && !dn_we) dn_rdata <= pat(dn_bus, dn_devfn, dn_reg);
  end

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One host access: driven at a negedge, request side observed in that cycle,
  // response observed two cycles later.
  task automatic acc(input bit sel, input bit we, input logic [1:0] off,
                     input logic [2:0] len, input logic [31:0] wd);
    host_req = 1'b1; host_sel = sel; host_we = we;
    host_off = off; host_len = len; host_wdata = wd;
    #1;
    o_req = dn_req; o_we = dn_we; o_bus = dn_bus; o_devfn = dn_devfn;
    o_reg = dn_reg; o_len = dn_len; o_wdata = dn_wdata;
    @(posedge clk); @(negedge clk);
    host_req = 1'b0;
    @(posedge clk); @(negedge clk);
    o_rvalid = host_rvalid; o_rdata = host_rdata;
  endtask

  task automatic set_addr(input logic [31:0] a);
    acc(1'b0, 1'b1, 2'd0, 3'd4, a);
  endtask

  task automatic data_case(input bit en, input int bus, input int dev, input int fn,
                           input logic [7:0] r, input logic [1:0] off, input int len,
                           input bit we, input logic [31:0] wd);
    logic [31:0] a, exp;
    int eff, fl;
    bit vis, ok;
    string tag;
    a = {en, 7'd0, 8'(bus), 5'(dev), 3'(fn), r};
    set_addr(a);
    eff = int'(r | {6'd0, off});
    vis = m_present(bus, dev, fn) && m_powered(dev) && !m_ejected(dev, fn)
          && !(m_hotplug(dev) && fn != 0 && !m_present(bus, dev, 0));
    ok  = en && (eff < LIM) && vis;
    fl  = ((LIM - eff) < len) ? (LIM - eff) : len;
    if (!en)                                     tag = "R4";
    else if (eff >= LIM)                         tag = "R9";
    else if (!m_present(bus, dev, fn))           tag = "R6";
    else if (!m_powered(dev) || m_ejected(dev, fn)) tag = "R7";
    else if (!vis)                               tag = "R8";
    else                                         tag = "R10";
    acc(1'b1, we, off, 3'(len), wd);
    chk_eq({tag, " request issued"}, 32'(o_req), 32'(ok));
    chk_eq("R5 target fields", {8'd0, o_bus, o_devfn, o_reg},
           {8'd0, 8'(bus), 5'(dev), 3'(fn), 8'(eff)});
    if (ok) begin
      chk_eq("R9 forwarded length", 32'(o_len), 32'(fl));
      chk_eq("R11 write flag", 32'(o_we), 32'(we));
      if (we) chk_eq("R11 write data", o_wdata, wd);
    end
    if (we) begin
      chk_eq("R10 no response on write", 32'(o_rvalid), 32'd0);
    end else begin
      exp = ok ? (pat(8'(bus), {5'(dev), 3'(fn)}, 8'(eff)) & lane_mask(fl)) : 32'hFFFF_FFFF;
      chk_eq("R10 response valid", 32'(o_rvalid), 32'd1);
      chk_eq({tag, " read data"}, o_rdata, exp);
    end
    chk_eq("R11 strobe single cycle", 32'(dn_req), 32'd0);
  endtask

  task automatic sweep_devices();
    logic [7:0] r;
    for (int bus = 0; bus < 3; bus++)
      for (int dev = 0; dev < 7; dev++)
        for (int fn = 0; fn < 4; fn++) begin
          r = 8'(8'h11 + dev * 4 + fn * 16);
          data_case(1'b1, bus, dev, fn, r, 2'd0, 4, 1'b0, 32'h0);
          data_case(1'b1, bus, dev, fn, r, 2'(fn), 1, 1'b0, 32'h0);
          data_case(1'b1, bus, dev, fn, r, 2'd2, 2, 1'b1, 32'hC0DE_0000 + 32'(dev));
        end
  endtask

  task automatic sweep_limit();
    int len;
    for (int rb = LIM - 8; rb < 256; rb += 4)
      for (int off = 0; off < 4; off++) begin
        for (int li = 0; li < 3; li++) begin
          len = (li == 2) ? 4 : li + 1;
          data_case(1'b1, 0, 1, 0, 8'(rb), 2'(off), len, 1'b0, 32'h0);
        end
        data_case(1'b1, 1, 0, 0, 8'(rb), 2'(off), 4, 1'b1, 32'hA1B2_C3D4);
      end
  endtask

  task automatic check_addr_port();
    logic [31:0] keep;
    int len;
    keep = 32'h8012_3456;
    set_addr(keep);
    acc(1'b0, 1'b1, 2'd1, 3'd4, 32'h1111_1111);
    acc(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
    chk_eq("R2 offset-1 write ignored", o_rdata, keep);
    acc(1'b0, 1'b1, 2'd0, 3'd2, 32'h2222_2222);
    acc(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
    chk_eq("R2 2-byte write ignored", o_rdata, keep);
    acc(1'b0, 1'b1, 2'd0, 3'd1, 32'h3333_3333);
    acc(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
    chk_eq("R2 1-byte write ignored", o_rdata, keep);
    acc(1'b0, 1'b1, 2'd3, 3'd1, 32'h4444_4444);
    acc(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
    chk_eq("R2 offset-3 write ignored", o_rdata, keep);
    for (int off = 0; off < 4; off++)
      for (int li = 0; li < 3; li++) begin
        len = (li == 2) ? 4 : li + 1;
        acc(1'b0, 1'b0, 2'(off), 3'(len), 32'h0);
        chk_eq("R3 address read full word", o_rdata, keep);
        chk_eq("R3 address read valid", 32'(o_rvalid), 32'd1);
      end
  endtask

  task automatic check_disabled();
    for (int dev = 0; dev < 3; dev++) begin
      data_case(1'b0, 0, dev, 0, 8'h20, 2'd0, 4, 1'b0, 32'h0);
      data_case(1'b0, 0, dev, 0, 8'h20, 2'd1, 1, 1'b1, 32'h5555_AAAA);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    host_req = 1'b0; host_we = 1'b0; host_sel = 1'b0;
    host_off = '0; host_len = 3'd4; host_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 rvalid low after reset", 32'(host_rvalid), 32'd0);
    chk_eq("R1 no request after reset", 32'(dn_req), 32'd0);
    acc(1'b0, 1'b0, 2'd0, 3'd4, 32'h0);
    chk_eq("R1 latch reads zero", o_rdata, 32'd0);
    acc(1'b1, 1'b0, 2'd0, 3'd4, 32'h0);
    chk_eq("R1 disabled data read", o_rdata, 32'hFFFF_FFFF);
    chk_eq("R1 no request while disabled", 32'(o_req), 32'd0);
    check_addr_port();
    check_disabled();
    sweep_devices();
    sweep_limit();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule